// File: doc/BRIEF.md
# Six-Level Thermometer March Self-Test Controller

This block is a built-in self-test engine for a memory whose cells each hold one of six signal levels. A level is carried on the memory port as a 5-bit thermometer code, so level k is the value with its k low bits set (00000, 00001, 00011, 00111, 01111, 11111). On a start pulse the engine runs a fixed march of seven elements over all n = 2^ADDR_W addresses. The first element writes level 0 everywhere. Each of the next five elements reads back the level the previous element left and then writes the next level up. The final element reads level 5. Every cell is therefore raised through all six levels, and each step up is preceded by a verify. That adds up to 12 operations per cell.

The engine drives a single synchronous request port. A request stays up until the memory acknowledges it, and read data is taken in the acknowledge cycle. Each read is compared with the level that is due. The first mismatch is latched: the address, the element index and the code actually read. A saturating counter counts every mismatch. When the march is over the engine raises done and reports pass, and holds both until the next start.

The controller is a five-state machine. IDLE waits for start. READ issues a read and waits for the acknowledge. WRITE issues a write and waits for the acknowledge. STEP moves the cursor to the next address or element. DONE holds the result. The transitions are:
- IDLE→WRITE on start, because element 0 has no read.
- READ→WRITE on acknowledge in elements 1 to 5.
- READ→STEP on acknowledge in element 6.
- WRITE→STEP on acknowledge.
- STEP→WRITE when the next address is still in element 0.
- STEP→READ for any other next operation.
- STEP→DONE after the last address of element 6.
- DONE→WRITE on start, which runs the march again.

Top module: `tm_march_bist`

## Requirements
- R1: After reset, done, pass, mem_req, fail_seen and fail_count are all 0.
- R2: Each element visits addresses 0 to n-1 in ascending order. Element 0 issues only a write per address and element 6 only a read. Elements 1 to 5 issue a read and then a write at each address before moving to the next address.
- R3: In element e, the write carries code (1<<e)-1. In element e, a read is expected to return code (1<<(e-1))-1. Thermometer codes fill from bit 0 upward.
- R4: One complete run issues exactly 12·n memory operations.
- R5: A request holds mem_addr, mem_we and mem_wdata stable until the cycle in which mem_ack is high. The operation completes in that cycle, and read data is sampled only in that cycle.
- R6: The first mismatching read sets fail_seen and latches fail_addr, fail_elem (the element index 0 to 6) and fail_code (the code read). Later mismatches leave these fields unchanged. A new start clears them.
- R7: fail_count increments once per mismatching read and saturates at 2^CNT_W-1.
- R8: done rises two cycles after the clock edge that accepts the final read, and then holds. pass is high only while done is high and fail_count is 0.
- R9: start is honoured only in IDLE or DONE. A start pulse during a run leaves the operation sequence and the results unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a march run (honoured in IDLE or DONE) |
| done | output | 1 | Run complete, held until the next start |
| pass | output | 1 | Run complete with no mismatch |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Cell address |
| mem_wdata | output | 5 | Thermometer code to write |
| mem_rdata | input | 5 | Code read, valid in the acknowledge cycle |
| mem_ack | input | 1 | Memory completes the current request |
| fail_seen | output | 1 | At least one mismatch in this run |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_elem | output | 3 | Element index of the first mismatch |
| fail_code | output | 5 | Code read at the first mismatch |
| fail_count | output | CNT_W | Saturating mismatch count |

## Verification
Several properties are checked on every cycle:
- A pending request stays stable until it is acknowledged.
- Every written value is a thermometer code.
- The mismatch count never drops within a run.
- The latched first-failure fields stay frozen once set.
- pass implies done with a zero count.
- No request is issued while done is high.

The bench scenarios cover the rest:
- The exact order and count of operations under a randomly stalling memory.
- Which element and code each stuck-high or stuck-low bit first exposes.
- How many reads each fault breaks.
- Saturation when every address is faulty.
- The two-cycle done latency.
- Immunity to a start pulse in mid-run.

// File: rtl/tmb_pkg.sv
package tmb_pkg;

    localparam int LEVELS   = 6;
    localparam int CODE_W   = LEVELS - 1;
    localparam int NUM_ELEM = LEVELS + 1;
    localparam int ELEM_W   = $clog2(NUM_ELEM);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_STEP,
        ST_DONE
    } tmb_state_e;

    // Thermometer code for a level: the low 'lvl' bits set.
    function automatic logic [CODE_W-1:0] level_code(input logic [ELEM_W-1:0] lvl);
        logic [CODE_W-1:0] code;
        for (int i = 0; i < CODE_W; i++) begin
            code[i] = (i < int'(lvl));
        end
        return code;
    endfunction

endpackage

// File: rtl/tmb_cursor.sv
module tmb_cursor
    import tmb_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [ELEM_W-1:0] elem,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_last,
    output logic              elem_last
);

    localparam logic [ELEM_W-1:0] ELEM_MAX = ELEM_W'(NUM_ELEM - 1);

    assign addr_last = (addr == {ADDR_W{1'b1}});
    assign elem_last = (elem == ELEM_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elem <= '0;
            addr <= '0;
        end else if (clear) begin
            elem <= '0;
            addr <= '0;
        end else if (step) begin
            if (addr_last) begin
                addr <= '0;
                if (!elem_last) begin
                    elem <= elem + ELEM_W'(1);
                end
            end else begin
                addr <= addr + ADDR_W'(1);
            end
        end
    end

endmodule

// File: rtl/tmb_fail_log.sv
module tmb_fail_log
    import tmb_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              check,
    input  logic [CODE_W-1:0] observed,
    input  logic [CODE_W-1:0] expected,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ELEM_W-1:0] elem,
    output logic              fail_seen,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [ELEM_W-1:0] fail_elem,
    output logic [CODE_W-1:0] fail_code,
    output logic [CNT_W-1:0]  fail_count
);

    logic mismatch;
    logic cnt_full;

    assign mismatch = check && (observed != expected);
    assign cnt_full = (fail_count == {CNT_W{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail_seen  <= 1'b0;
            fail_addr  <= '0;
            fail_elem  <= '0;
            fail_code  <= '0;
            fail_count <= '0;
        end else if (clear) begin
            fail_seen  <= 1'b0;
            fail_addr  <= '0;
            fail_elem  <= '0;
            fail_code  <= '0;
            fail_count <= '0;
        end else if (mismatch) begin
            if (!fail_seen) begin
                fail_seen <= 1'b1;
                fail_addr <= addr;
                fail_elem <= elem;
                fail_code <= observed;
            end
            if (!cnt_full) begin
                fail_count <= fail_count + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/tm_march_bist.sv
module tm_march_bist
    import tmb_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              done,
    output logic              pass,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [4:0]        mem_wdata,
    input  logic [4:0]        mem_rdata,
    input  logic              mem_ack,
    output logic              fail_seen,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [2:0]        fail_elem,
    output logic [4:0]        fail_code,
    output logic [CNT_W-1:0]  fail_count
);

    tmb_state_e        state, state_nx;
    logic [ELEM_W-1:0] elem;
    logic [ADDR_W-1:0] addr;
    logic              addr_last, elem_last;
    logic              run_clear, cur_step, rd_check;
    logic              final_op;
    logic [CODE_W-1:0] rd_expect, wr_code;

    assign final_op  = addr_last && elem_last;
    assign run_clear = start && ((state == ST_IDLE) || (state == ST_DONE));
    assign cur_step  = (state == ST_STEP) && !final_op;
    assign rd_check  = (state == ST_READ) && mem_ack;
    assign wr_code   = level_code(elem);
    assign rd_expect = level_code(elem - ELEM_W'(1));

    tmb_cursor #(.ADDR_W(ADDR_W)) u_cursor (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (run_clear),
        .step      (cur_step),
        .elem      (elem),
        .addr      (addr),
        .addr_last (addr_last),
        .elem_last (elem_last)
    );

    tmb_fail_log #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_log (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (run_clear),
        .check      (rd_check),
        .observed   (mem_rdata),
        .expected   (rd_expect),
        .addr       (addr),
        .elem       (elem),
        .fail_seen  (fail_seen),
        .fail_addr  (fail_addr),
        .fail_elem  (fail_elem),
        .fail_code  (fail_code),
        .fail_count (fail_count)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_WRITE;
            ST_READ:  if (mem_ack) state_nx = elem_last ? ST_STEP : ST_WRITE;
            ST_WRITE: if (mem_ack) state_nx = ST_STEP;
            ST_STEP: begin
                if (final_op) begin
                    state_nx = ST_DONE;
                end else if (!addr_last && (elem == '0)) begin
                    state_nx = ST_WRITE;
                end else begin
                    state_nx = ST_READ;
                end
            end
            ST_DONE:  if (start) state_nx = ST_WRITE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        done      = 1'b0;
        unique case (state)
            ST_READ:  mem_req = 1'b1;
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = wr_code;
            end
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

    assign mem_addr = addr;
    assign pass     = done && (fail_count == '0);

endmodule

// File: rtl/tmb_checker.sv
module tmb_checker #(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input logic              pass,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [4:0]        mem_wdata,
    input logic              fail_seen,
    input logic [ADDR_W-1:0] fail_addr,
    input logic [2:0]        fail_elem,
    input logic [4:0]        fail_code,
    input logic [CNT_W-1:0]  fail_count
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata))); // R5

    AST_WDATA_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ((mem_wdata & (mem_wdata + 5'd1)) == 5'd0)); // R3

    AST_FIRST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_seen && !start) |=> (fail_seen && $stable(fail_addr) && $stable(fail_elem) && $stable(fail_code))); // R6

    AST_COUNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (fail_count >= $past(fail_count))); // R7

    AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> (done && (fail_count == '0))); // R8

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req); // R8

endmodule

bind tm_march_bist tmb_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .done       (done),
    .pass       (pass),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .fail_seen  (fail_seen),
    .fail_addr  (fail_addr),
    .fail_elem  (fail_elem),
    .fail_code  (fail_code),
    .fail_count (fail_count)
);

// File: tb/sim_tm_march_bist.sv
module sim_tm_march_bist;

    localparam int CLK_PERIOD = 10;
    localparam int AW   = 4;
    localparam int CW   = 3;
    localparam int N    = 1 << AW;
    localparam int SATV = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          done, pass, mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [4:0]    mem_wdata, mem_rdata;
    logic          fail_seen;
    logic [AW-1:0] fail_addr;
    logic [2:0]    fail_elem;
    logic [4:0]    fail_code;
    logic [CW-1:0] fail_count;

    int checks = 0;
    int errors = 0;

    // memory model and fault configuration
    logic [4:0] mem [N];
    int  fmode = 0;           // 0 none, 1 stuck-high, 2 stuck-low
    int  fbit  = 0;
    int  faddr = 0;
    bit  fall  = 1'b0;
    bit  stall_en = 1'b0;
    logic go = 1'b1;
    logic [7:0] lfsr = 8'h5a;

    // monitor state
    int cyc = 0;
    int op_cnt = 0;
    int trace_err = 0;
    int last_op_cyc = 0;
    bit done_seen = 1'b0;
    int done_lat = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tm_march_bist #(.ADDR_W(AW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done), .pass(pass),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .fail_seen(fail_seen), .fail_addr(fail_addr), .fail_elem(fail_elem),
        .fail_code(fail_code), .fail_count(fail_count)
    );

    assign mem_ack = mem_req && go;

    always_comb begin
        logic [4:0] v;
        v = mem[mem_addr];
        if (fall || (int'(mem_addr) == faddr)) begin
            if (fmode == 1) v = v | (5'd1 << fbit);
            if (fmode == 2) v = v & ~(5'd1 << fbit);
        end
        mem_rdata = mem_ack ? v : 5'b10110;
    end

    always @(posedge clk) begin
        if (mem_req && mem_ack && mem_we) mem[mem_addr] <= mem_wdata;
    end

    function automatic int thermo(input int k);
        return (1 << k) - 1;
    endfunction

    // expected op k: {we, addr, write data}
    function automatic logic [9:0] exp_op(input int k);
        int we, a, d, j, e, r;
        if (k < N) begin
            we = 1; a = k; d = 0;
        end else if (k < 11*N) begin
            j = k - N; e = 1 + j / (2*N); r = j % (2*N);
            a = r / 2; we = r % 2; d = we ? thermo(e) : 0;
        end else begin
            we = 0; a = k - 11*N; d = 0;
        end
        return {we[0], a[AW-1:0], d[4:0]};
    endfunction

    always @(negedge clk) begin
        logic [9:0] ex;
        cyc++;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        go = stall_en ? (lfsr[0] | lfsr[1]) : 1'b1;
        if (rst_n && mem_req && go) begin
            ex = exp_op(op_cnt);
            if (op_cnt >= 12*N) trace_err++;
            else if (mem_we != ex[9] || mem_addr != ex[8:5] ||
                     (mem_we && mem_wdata != ex[4:0])) trace_err++;
            op_cnt++;
            last_op_cyc = cyc;
        end
        if (rst_n && done && !done_seen) begin
            done_seen = 1'b1;
            done_lat  = cyc - last_op_cyc;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run(input int mode, input int b, input int a, input bit all,
                       input bit stall, input bit poke);
        int per, naddr, tot, exp_cnt, e_elem, e_code, e_addr, wd;
        fmode = mode; fbit = b; faddr = a; fall = all; stall_en = stall;
        @(negedge clk);
        start = 1'b1; op_cnt = 0; trace_err = 0;
        @(negedge clk);
        start = 1'b0; done_seen = 1'b0;
        if (poke) begin
            repeat (40) @(negedge clk);
            start = 1'b1;                     // R9: ignored mid-run
            @(negedge clk);
            start = 1'b0;
        end
        wd = 0;
        while (!done_seen && wd < 5000) begin
            @(negedge clk);
            wd++;
        end
        check(done_seen, "R8", "run timeout", wd, 0);
        // expected results
        per = 0; e_elem = 0; e_code = 0;
        if (mode == 1) begin
            per = b + 1; e_elem = 1; e_code = 1 << b;
        end else if (mode == 2) begin
            per = 5 - b; e_elem = b + 2; e_code = thermo(b + 1) & ~(1 << b);
        end
        naddr = all ? N : 1;
        e_addr = all ? 0 : a;
        tot = per * naddr;
        exp_cnt = (tot > SATV) ? SATV : tot;
        check(op_cnt == 12*N, "R4", "op count", op_cnt, 12*N);
        check(trace_err == 0, "R2 R3", "order/code mismatches", trace_err, 0);
        check(done_lat == 2, "R8", "done latency", done_lat, 2);
        check(int'(fail_count) == exp_cnt, "R7", "fail_count", int'(fail_count), exp_cnt);
        check(pass == (exp_cnt == 0), "R8", "pass", int'(pass), int'(exp_cnt == 0));
        check(fail_seen == (exp_cnt != 0), "R6", "fail_seen", int'(fail_seen), int'(exp_cnt != 0));
        if (exp_cnt != 0) begin
            check(int'(fail_addr) == e_addr, "R6", "fail_addr", int'(fail_addr), e_addr);
            check(int'(fail_elem) == e_elem, "R6", "fail_elem", int'(fail_elem), e_elem);
            check(int'(fail_code) == e_code, "R6", "fail_code", int'(fail_code), e_code);
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) mem[i] = 5'b11111;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!done && !pass && !mem_req, "R1", "idle outputs",
              int'({done, pass, mem_req}), 0);
        check(!fail_seen && fail_count == '0, "R1", "fail state",
              int'(fail_count), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!mem_req && !done, "R1", "no activity without start",
              int'({mem_req, done}), 0);

        run(0, 0, 0, 1'b0, 1'b0, 1'b0);     // clean, zero-wait
        run(0, 0, 0, 1'b0, 1'b1, 1'b0);     // clean, stalls (R5)
        for (int b = 0; b < 5; b++) run(1, b, 5, 1'b0, 1'b1, 1'b0);
        for (int b = 0; b < 5; b++) run(2, b, N-1, 1'b0, 1'b1, 1'b0);
        run(1, 2, 0, 1'b0, 1'b0, 1'b0);
        run(1, 0, 0, 1'b1, 1'b1, 1'b0);     // 16 fails, saturates (R7)
        run(2, 4, 0, 1'b1, 1'b0, 1'b0);     // 16 fails, saturates
        run(0, 0, 0, 1'b0, 1'b1, 1'b1);     // R9 clean with mid-run start
        run(2, 1, 9, 1'b0, 1'b0, 1'b1);     // R9 faulty with mid-run start
        run(0, 0, 0, 1'b0, 1'b0, 1'b0);     // R6 restart clears log

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule